// File: doc/BRIEF.md
# Register Rename Map with Free List

The block translates architectural register names into physical register numbers for an out-of-order core. Each cycle one instruction may present two source names and one destination name. The sources are looked up in a speculative map. A destination other than register 0 takes the lowest-numbered free physical register. The block also returns the physical register that the destination was mapped to before, so that the retirement logic can free it later.

A second, committed map holds the architectural state. When an instruction retires, its physical destination becomes the architectural copy of that register, and the register it replaces goes back to the free list. On a misprediction, a single recover pulse discards every speculative rename at once. The speculative map is overwritten by the committed map, and every physical register that the committed map does not use becomes free again.

Top module: `rmap_rename`

## Requirements
- R1: After reset both maps send architectural register i to physical register i, and physical registers 16 to 47 are free, so the first destination allocated is 16.
- R2: `iss_psrc1` and `iss_psrc2` show the speculative mapping of the source names as it stands before the current instruction's own rename. This includes renames made by earlier instructions.
- R3: A fired issue with a nonzero destination receives the lowest-numbered free physical register on `iss_pdst`. `iss_pold` returns the previous speculative mapping of that destination.
- R4: A physical register handed out is not handed out again until it has been freed by a commit or by recovery.
- R5: With the free list empty and a nonzero destination, `iss_ready` is low, and an issue presented then changes no state.
- R6: A destination of register 0 is neither renamed nor allocated. `iss_pdst` is 0 and `iss_ready` is high (outside recovery), even when the free list is empty.
- R7: A commit of a nonzero destination records `cmt_pdst` in the committed map and frees the physical register previously held there. That register is available for allocation in the next cycle.
- R8: On `rec_valid`, the speculative map becomes the committed map, with any commit in the same cycle applied first. The free list becomes every register not in that map. `iss_ready` is low in that cycle, and no issue takes effect.
- R9: A commit whose destination is register 0 changes neither map nor the free list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue slot holds an instruction |
| iss_src1 | input | 4 | First architectural source |
| iss_src2 | input | 4 | Second architectural source |
| iss_dst | input | 4 | Architectural destination (0 = none) |
| iss_ready | output | 1 | Issue can be accepted this cycle |
| iss_psrc1 | output | 6 | Physical tag of first source |
| iss_psrc2 | output | 6 | Physical tag of second source |
| iss_pdst | output | 6 | Newly allocated physical destination |
| iss_pold | output | 6 | Previous speculative mapping of destination |
| cmt_valid | input | 1 | An instruction retires |
| cmt_dst | input | 4 | Architectural destination of retiring instruction |
| cmt_pdst | input | 6 | Physical destination of retiring instruction |
| rec_valid | input | 1 | Discard all speculative renames |

## Verification
The assertions assume that retirement follows issue order. Each commit must carry a destination pair that was issued and has not been discarded, so that the committed map always stays a permutation of distinct physical registers. The bench keeps its own queue of issued renames. It commits only from the head of that queue and empties the queue on every recover pulse. Random issue, commit and recover mixes therefore stay legal, while directed runs drain the free list completely and commit register 0.

// File: rtl/rmap_pkg.sv
package rmap_pkg;
    localparam int ARCH_REGS = 16;
    localparam int PHYS_REGS = 48;
endpackage

// File: rtl/rmap_free_pick.sv
module rmap_free_pick #(
    parameter int N  = 48,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/rmap_used_mask.sv
module rmap_used_mask #(
    parameter int NA = 16,
    parameter int NP = 48,
    parameter int PW = $clog2(NP)
) (
    input  logic [NA-1:0][PW-1:0] map,
    output logic [NP-1:0]         used
);
    for (genvar p = 0; p < NP; p++) begin : g_phys
        always_comb begin
            used[p] = 1'b0;
            for (int a = 0; a < NA; a++) begin
                if (map[a] == PW'(p)) used[p] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rmap_rename.sv
module rmap_rename
    import rmap_pkg::*;
#(
    parameter int NA = ARCH_REGS,
    parameter int NP = PHYS_REGS,
    localparam int AW = $clog2(NA),
    localparam int PW = $clog2(NP)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iss_valid,
    input  logic [AW-1:0] iss_src1,
    input  logic [AW-1:0] iss_src2,
    input  logic [AW-1:0] iss_dst,
    output logic          iss_ready,
    output logic [PW-1:0] iss_psrc1,
    output logic [PW-1:0] iss_psrc2,
    output logic [PW-1:0] iss_pdst,
    output logic [PW-1:0] iss_pold,
    input  logic          cmt_valid,
    input  logic [AW-1:0] cmt_dst,
    input  logic [PW-1:0] cmt_pdst,
    input  logic          rec_valid
);
    typedef struct packed {
        logic [NA-1:0][PW-1:0] spec;
        logic [NA-1:0][PW-1:0] cmt;
        logic [NP-1:0]         free;
    } state_t;

    state_t state_q, state_d;

    logic          pick_found;
    logic [PW-1:0] pick_idx;
    logic [NP-1:0] cmt_used;
    logic          dst_live, iss_fire, cmt_live;
    logic [PW-1:0] cmt_old;
    logic [NP-1:0] free_rec;

    rmap_free_pick #(.N(NP), .IW(PW)) u_pick (
        .vec   (state_q.free),
        .found (pick_found),
        .idx   (pick_idx)
    );

    rmap_used_mask #(.NA(NA), .NP(NP), .PW(PW)) u_used (
        .map  (state_q.cmt),
        .used (cmt_used)
    );

    assign dst_live  = (iss_dst != '0);
    assign iss_ready = !rec_valid && (!dst_live || pick_found);
    assign iss_fire  = iss_valid && iss_ready;
    assign iss_psrc1 = state_q.spec[iss_src1];
    assign iss_psrc2 = state_q.spec[iss_src2];
    assign iss_pold  = state_q.spec[iss_dst];
    assign iss_pdst  = dst_live ? pick_idx : '0;
    assign cmt_live  = cmt_valid && (cmt_dst != '0);
    assign cmt_old   = state_q.cmt[cmt_dst];

    always_comb begin
        state_d  = state_q;
        free_rec = ~cmt_used;
        if (iss_fire && dst_live) begin
            state_d.free[pick_idx] = 1'b0;
            state_d.spec[iss_dst]  = pick_idx;
        end
        if (cmt_live) begin
            state_d.free[cmt_old]  = 1'b1;
            state_d.cmt[cmt_dst]   = cmt_pdst;
            free_rec[cmt_old]      = 1'b1;
            free_rec[cmt_pdst]     = 1'b0;
        end
        if (rec_valid) begin
            state_d.spec = state_d.cmt;
            state_d.free = free_rec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NA; i++) begin
                state_q.spec[i] <= PW'(i);
                state_q.cmt[i]  <= PW'(i);
            end
            for (int p = 0; p < NP; p++) begin
                state_q.free[p] <= (p >= NA);
            end
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/rmap_rename_chk.sv
module rmap_rename_chk #(
    parameter int NA = 16,
    parameter int NP = 48,
    localparam int AW = $clog2(NA),
    localparam int PW = $clog2(NP)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          iss_valid,
    input logic [AW-1:0] iss_dst,
    input logic          iss_ready,
    input logic [PW-1:0] iss_pdst,
    input logic          rec_valid,
    input logic [NP-1:0] free_vec
);
    // R3
    alloc_from_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready && iss_dst != '0) |-> free_vec[iss_pdst]);

    // R4
    alloc_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready && iss_dst != '0) |=> !free_vec[$past(iss_pdst)]);

    // R5
    empty_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (free_vec == '0 && iss_dst != '0) |-> !iss_ready);

    // R6
    zero_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_dst == '0 && !rec_valid) |-> (iss_ready && iss_pdst == '0));

    // R8
    recover_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> !iss_ready);

    // R8
    recover_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |=> ($countones(free_vec) == NP - NA));
endmodule

bind rmap_rename rmap_rename_chk #(.NA(NA), .NP(NP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .iss_dst   (iss_dst),
    .iss_ready (iss_ready),
    .iss_pdst  (iss_pdst),
    .rec_valid (rec_valid),
    .free_vec  (state_q.free)
);

// File: tb/rmap_rename_test.sv
module rmap_rename_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       iss_valid = 1'b0;
    logic [3:0] iss_src1 = '0, iss_src2 = '0, iss_dst = '0;
    logic       iss_ready;
    logic [5:0] iss_psrc1, iss_psrc2, iss_pdst, iss_pold;
    logic       cmt_valid = 1'b0;
    logic [3:0] cmt_dst = '0;
    logic [5:0] cmt_pdst = '0;
    logic       rec_valid = 1'b0;

    always #4 clk = ~clk;

    rmap_rename uut (.*);

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    int m_spec[16], m_cmt[16];
    bit m_free[48];
    int q_dst[64], q_pd[64];
    int q_head = 0, q_tail = 0, q_cnt = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int m_pick();
        for (int p = 0; p < 48; p++) if (m_free[p]) return p;
        return -1;
    endfunction

    task automatic m_reset();
        for (int i = 0; i < 16; i++) begin m_spec[i] = i; m_cmt[i] = i; end
        for (int p = 0; p < 48; p++) m_free[p] = (p >= 16);
        q_head = 0; q_tail = 0; q_cnt = 0;
    endtask

    // one cycle: drive, check combinational outputs, advance the model
    task automatic cycle(input bit iv, input int s1, input int s2, input int d,
                         input bit cv, input int cd, input int cp, input bit rv);
        int pk, old;
        bit er;
        string tg;
        @(negedge clk);
        iss_valid = iv; iss_src1 = 4'(s1); iss_src2 = 4'(s2); iss_dst = 4'(d);
        cmt_valid = cv; cmt_dst = 4'(cd); cmt_pdst = 6'(cp); rec_valid = rv;
        #1;
        pk = m_pick();
        er = !rv && (d == 0 || pk >= 0);
        tg = rv ? "R8" : (d == 0 ? "R6" : (pk < 0 ? "R5" : "R3"));
        chk({tg, " ready"}, int'(iss_ready), int'(er));
        if (iv && er) begin
            chk("R2 psrc1", int'(iss_psrc1), m_spec[s1]);
            chk("R2 psrc2", int'(iss_psrc2), m_spec[s2]);
            chk("R3 pold", int'(iss_pold), m_spec[d]);
            chk(d == 0 ? "R6 pdst" : "R3 pdst", int'(iss_pdst), d == 0 ? 0 : pk);
            if (d != 0) chk("R4 pdst was free", int'(m_free[iss_pdst]), 1);
        end
        if (iv && er && d != 0) begin
            m_free[pk] = 0; m_spec[d] = pk;
            q_dst[q_tail] = d; q_pd[q_tail] = pk; q_tail = (q_tail + 1) % 64; q_cnt++;
        end
        if (cv && cd != 0) begin
            old = m_cmt[cd]; m_cmt[cd] = cp; m_free[old] = 1;
        end
        if (rv) begin
            for (int i = 0; i < 16; i++) m_spec[i] = m_cmt[i];
            for (int p = 0; p < 48; p++) m_free[p] = 1;
            for (int i = 0; i < 16; i++) m_free[m_cmt[i]] = 0;
            q_head = 0; q_tail = 0; q_cnt = 0;
        end
    endtask

    task automatic commit_head(input bit iv, input int s1, input int s2, input int d, input bit rv);
        int cd, cp;
        cd = q_dst[q_head]; cp = q_pd[q_head];
        q_head = (q_head + 1) % 64; q_cnt--;
        cycle(iv, s1, s2, d, 1, cd, cp, rv);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: identity map after reset, first allocation is 16
        for (int i = 0; i < 16; i++) begin
            cycle(1, i, 15 - i, 0, 0, 0, 0, 0);
            chk("R1 identity", int'(iss_psrc1), i);
        end
        cycle(1, 3, 4, 7, 0, 0, 0, 0);
        chk("R1 first alloc", int'(iss_pdst), 16);
        // R2: later source sees earlier rename
        cycle(1, 7, 7, 9, 0, 0, 0, 0);
        chk("R2 renamed src", int'(iss_psrc1), 16);

        // drain the free list (R4 on each pdst)
        while (m_pick() >= 0) cycle(1, 1, 2, 5, 0, 0, 0, 0);
        // R5: stall when empty
        cycle(1, 1, 2, 5, 0, 0, 0, 0);
        chk("R5 empty stall", int'(iss_ready), 0);
        cycle(1, 5, 2, 6, 0, 0, 0, 0);
        // R6: dst 0 goes through when empty
        cycle(1, 5, 5, 0, 0, 0, 0, 0);
        chk("R6 zero dst ready", int'(iss_ready), 1);
        chk("R6 zero dst pdst", int'(iss_pdst), 0);

        // R7: committing the first rename frees physical 7
        commit_head(0, 0, 0, 0, 0);
        cycle(1, 0, 0, 3, 0, 0, 0, 0);
        chk("R7 freed reused", int'(iss_pdst), 7);

        // R9: commit of register 0 has no effect
        cycle(0, 0, 0, 0, 1, 0, 40, 0);
        // R8: recover with a commit in the same cycle
        commit_head(1, 9, 9, 4, 1);
        cycle(1, 9, 0, 0, 0, 0, 0, 0);
        chk("R8 recovered map", int'(iss_psrc1), m_cmt[9]);
        chk("R9 map 0 unchanged", int'(iss_psrc2), 0);
        cycle(1, 1, 1, 2, 0, 0, 0, 0);
        chk("R8 rebuilt free", int'(iss_pdst), 7);

        // constrained random mix
        for (int n = 0; n < 4000; n++) begin
            bit iv, cv, rv;
            iv = ($urandom % 4) != 0;
            cv = (q_cnt > 0) && (($urandom % 3) == 0);
            rv = ($urandom % 80) == 0;
            if (cv) commit_head(iv, $urandom % 16, $urandom % 16, $urandom % 16, rv);
            else    cycle(iv, $urandom % 16, $urandom % 16, $urandom % 16, 0, 0, 0, rv);
        end

        done = 1;
        summary();
        $finish;
    end
endmodule